// File: doc/BRIEF.md
# DMA End-of-Buffer Interrupt Status

This block holds the end-of-buffer interrupt status of a descriptor-based DMA engine. There is one bit per channel, in a transmit status register and a receive status register. Both registers follow the same rules. The descriptor engine reports each buffer status write-back as a single-cycle event. Each event carries a channel index and the qualifying flags of that descriptor: interrupt request, last buffer of a packet, packet backed up, and bad packet.

A channel bit sets when any one of three paths fires for a write-back event:

- the descriptor's interrupt-request flag is set;
- the event ends a packet that is not backed up, and the global end-of-packet interrupt enable is on;
- the bad-packet flag is set.

Software clears bits by writing ones through a small register port. Each direction drives one registered interrupt line, which is the OR of its implemented bits.

Top module: `eob_irq_status`

## Requirements
- R1: A synchronous active-high reset clears every status bit and drops both interrupt lines.
- R2: A write-back event with its interrupt-request flag set sets the status bit for the event's channel, where bit i belongs to channel i, in the cycle after the strobe. An event with no qualifying flag leaves the status unchanged.
- R3: An event with the last-buffer flag set sets the channel's bit only while the global end-of-packet enable is high.
- R4: A last-buffer event with the backed-up flag set does not set the bit through the end-of-packet path. Its interrupt-request and bad-packet paths still act.
- R5: An event with the bad-packet flag set sets the channel's bit, whatever the end-of-packet enable is.
- R6: A register write with select 0 (transmit) or 1 (receive) clears each status bit whose data bit is 1. Bits whose data bit is 0 are unchanged.
- R7: If a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R8: Each interrupt line is high exactly one cycle after its direction's status has any bit set.
- R9: Transmit implements bits 0 and 1, and receive implements bit 0 only. All other bit positions read as 0 on the status outputs and on the read port. An event whose channel index has no implemented bit is ignored.
- R10: A write to one direction's register leaves the other direction's status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eop_irq_en | input | 1 | Global end-of-packet interrupt enable |
| tx_evt_stb | input | 1 | Transmit write-back event strobe |
| tx_evt_chan | input | 1 | Transmit event channel index |
| tx_evt_irq | input | 1 | Descriptor interrupt-request flag |
| tx_evt_last | input | 1 | Last buffer of packet flag |
| tx_evt_backup | input | 1 | Packet backed-up flag |
| tx_evt_bad | input | 1 | Bad-packet flag |
| rx_evt_stb | input | 1 | Receive write-back event strobe |
| rx_evt_chan | input | 1 | Receive event channel index |
| rx_evt_irq | input | 1 | Descriptor interrupt-request flag |
| rx_evt_last | input | 1 | Last buffer of packet flag |
| rx_evt_backup | input | 1 | Packet backed-up flag |
| rx_evt_bad | input | 1 | Bad-packet flag |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 transmit, 1 receive |
| wr_data | input | 32 | Write-one-to-clear data |
| rd_sel | input | 1 | Read source: 0 transmit, 1 receive |
| rd_data | output | 32 | Selected status, reserved bits zero |
| tx_status | output | 32 | Transmit status register |
| rx_status | output | 32 | Receive status register |
| tx_irq | output | 1 | Registered transmit interrupt |
| rx_irq | output | 1 | Registered receive interrupt |

## Verification
An event or clear applied before edge n shows in the status outputs just after edge n. The interrupt lines follow one edge later, at n+1. The read port is combinational from the status, so it is valid once the select has settled. For every stimulus the driver queues expected items tagged with the cycle in which they fall due. The status items are due one cycle after the stimulus and the interrupt items two cycles after. A monitor compares each item at the falling edge of its own cycle and reports any item left past its cycle as a failure.

// File: rtl/eob_pkg.sv
package eob_pkg;

    localparam int REG_W     = 32;
    localparam int CH_IDX_W  = 1;

    localparam logic SEL_TX = 1'b0;
    localparam logic SEL_RX = 1'b1;

    typedef struct packed {
        logic                strobe;
        logic [CH_IDX_W-1:0] chan;
        logic                irq_req;
        logic                last_buf;
        logic                backed_up;
        logic                bad_pkt;
    } wb_event_t;

    // True when a write-back event qualifies to raise its channel's bit.
    function automatic logic event_qualifies(input wb_event_t ev, input logic eop_en);
        logic eop_path;
        eop_path = ev.last_buf && eop_en && !ev.backed_up;
        return ev.strobe && (ev.irq_req || eop_path || ev.bad_pkt);
    endfunction

endpackage

// File: rtl/eob_set_decode.sv
module eob_set_decode
    import eob_pkg::*;
#(
    parameter int NCH = 2
) (
    input  wb_event_t        ev,
    input  logic             eop_en,
    output logic [NCH-1:0]   set_mask
);

    logic qualified;

    always_comb qualified = event_qualifies(ev, eop_en);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_comb set_mask[c] = qualified && (int'(ev.chan) == c);
    end

endmodule

// File: rtl/eob_status_reg.sv
module eob_status_reg #(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   set_mask,
    input  logic [NCH-1:0]   clr_mask,
    output logic [NCH-1:0]   bits
);

    // Set wins over a same-cycle write-one clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
        end else begin
            bits <= (bits & ~clr_mask) | set_mask;
        end
    end

endmodule

// File: rtl/eob_irq_reduce.sv
module eob_irq_reduce #(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   bits,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |bits;
        end
    end

endmodule

// File: rtl/eob_irq_status.sv
module eob_irq_status
    import eob_pkg::*;
#(
    parameter int TX_CH = 2,
    parameter int RX_CH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eop_irq_en,
    input  logic             tx_evt_stb,
    input  logic             tx_evt_chan,
    input  logic             tx_evt_irq,
    input  logic             tx_evt_last,
    input  logic             tx_evt_backup,
    input  logic             tx_evt_bad,
    input  logic             rx_evt_stb,
    input  logic             rx_evt_chan,
    input  logic             rx_evt_irq,
    input  logic             rx_evt_last,
    input  logic             rx_evt_backup,
    input  logic             rx_evt_bad,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             rd_sel,
    output logic [31:0]      rd_data,
    output logic [31:0]      tx_status,
    output logic [31:0]      rx_status,
    output logic             tx_irq,
    output logic             rx_irq
);

    localparam int MAX_CH = (TX_CH > RX_CH) ? TX_CH : RX_CH;

    wb_event_t          tx_ev, rx_ev;
    logic [TX_CH-1:0]   tx_set, tx_clr, tx_bits;
    logic [RX_CH-1:0]   rx_set, rx_clr, rx_bits;
    logic               unused_wr_hi;

    always_comb begin
        tx_ev = '{strobe: tx_evt_stb, chan: tx_evt_chan, irq_req: tx_evt_irq,
                  last_buf: tx_evt_last, backed_up: tx_evt_backup, bad_pkt: tx_evt_bad};
        rx_ev = '{strobe: rx_evt_stb, chan: rx_evt_chan, irq_req: rx_evt_irq,
                  last_buf: rx_evt_last, backed_up: rx_evt_backup, bad_pkt: rx_evt_bad};
    end

    always_comb begin
        tx_clr = (wr_en && wr_sel == SEL_TX) ? wr_data[TX_CH-1:0] : '0;
        rx_clr = (wr_en && wr_sel == SEL_RX) ? wr_data[RX_CH-1:0] : '0;
    end

    assign unused_wr_hi = ^wr_data[REG_W-1:MAX_CH];

    eob_set_decode #(.NCH(TX_CH)) u_tx_dec (
        .ev(tx_ev), .eop_en(eop_irq_en), .set_mask(tx_set)
    );

    eob_set_decode #(.NCH(RX_CH)) u_rx_dec (
        .ev(rx_ev), .eop_en(eop_irq_en), .set_mask(rx_set)
    );

    eob_status_reg #(.NCH(TX_CH)) u_tx_reg (
        .clk(clk), .rst(rst), .set_mask(tx_set), .clr_mask(tx_clr), .bits(tx_bits)
    );

    eob_status_reg #(.NCH(RX_CH)) u_rx_reg (
        .clk(clk), .rst(rst), .set_mask(rx_set), .clr_mask(rx_clr), .bits(rx_bits)
    );

    eob_irq_reduce #(.NCH(TX_CH)) u_tx_irq (
        .clk(clk), .rst(rst), .bits(tx_bits), .irq(tx_irq)
    );

    eob_irq_reduce #(.NCH(RX_CH)) u_rx_irq (
        .clk(clk), .rst(rst), .bits(rx_bits), .irq(rx_irq)
    );

    always_comb begin
        tx_status = {{(REG_W-TX_CH){1'b0}}, tx_bits};
        rx_status = {{(REG_W-RX_CH){1'b0}}, rx_bits};
        rd_data   = (rd_sel == SEL_RX) ? rx_status : tx_status;
    end

endmodule

// File: rtl/eob_irq_status_chk.sv
module eob_irq_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        eop_irq_en,
    input logic        tx_evt_stb,
    input logic        tx_evt_chan,
    input logic        tx_evt_irq,
    input logic        tx_evt_last,
    input logic        tx_evt_backup,
    input logic        tx_evt_bad,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] tx_status,
    input logic [31:0] rx_status,
    input logic        tx_irq,
    input logic        rx_irq
);

    // R8: interrupt follows any set bit by one cycle
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (|tx_status) |=> tx_irq);
    p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_status == 32'd0) |=> !rx_irq);

    // R7 / R2: a qualifying tx event on a channel sets that bit even under a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_evt_stb && (tx_evt_irq || tx_evt_bad)) |=> tx_status[$past(tx_evt_chan)]);

    // R4: backed-up last buffer with no other flag leaves channel 0 untouched
    p_backup_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_evt_stb && tx_evt_chan == 1'b0 && tx_evt_last && tx_evt_backup
         && !tx_evt_irq && !tx_evt_bad && !tx_status[0]) |=> !tx_status[0]);

    // R6: write-one clears tx bit 0 when no event targets it
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_data[0] && !(tx_evt_stb && tx_evt_chan == 1'b0))
        |=> !tx_status[0]);

    // R6 / R10: no strobe and no tx write keeps tx status stable
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tx_evt_stb && !(wr_en && !wr_sel)) |=> $stable(tx_status));

    // R3: with enable low, a plain last-buffer event does not set channel 1
    p_eop_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_evt_stb && tx_evt_chan && tx_evt_last && !eop_irq_en
         && !tx_evt_irq && !tx_evt_bad && !tx_status[1]) |=> !tx_status[1]);

    // R9: reserved positions stay zero
    always_comb begin
        if (!rst) begin
            p_reserved_r9: assert (tx_status[31:2] == 30'd0 && rx_status[31:1] == 31'd0);
        end
    end

endmodule

bind eob_irq_status eob_irq_status_chk u_chk (
    .clk(clk), .rst(rst), .eop_irq_en(eop_irq_en),
    .tx_evt_stb(tx_evt_stb), .tx_evt_chan(tx_evt_chan), .tx_evt_irq(tx_evt_irq),
    .tx_evt_last(tx_evt_last), .tx_evt_backup(tx_evt_backup), .tx_evt_bad(tx_evt_bad),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_status(tx_status), .rx_status(rx_status), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/sim_eob_irq_status.sv
module sim_eob_irq_status;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eop_irq_en = 1'b0;
    logic tx_evt_stb = 0, tx_evt_chan = 0, tx_evt_irq = 0, tx_evt_last = 0, tx_evt_backup = 0, tx_evt_bad = 0;
    logic rx_evt_stb = 0, rx_evt_chan = 0, rx_evt_irq = 0, rx_evt_last = 0, rx_evt_backup = 0, rx_evt_bad = 0;
    logic wr_en = 0, wr_sel = 0, rd_sel = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, tx_status, rx_status;
    logic tx_irq, rx_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    eob_irq_status u0 (.*);

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    logic [31:0] m_tx = '0, m_rx = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] actual_of(int kind);
        case (kind)
            0: return tx_status;
            1: return rx_status;
            2: return {31'd0, tx_irq};
            default: return {31'd0, rx_irq};
        endcase
    endfunction

    // Monitor: compares queued items in the cycle they fall due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = actual_of(it.kind);
            checks++;
            if (it.cyc < cyc) begin
                fails++;
                $display("FAIL %s kind%0d: item missed its cycle, actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end else if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind%0d: actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] set_of(int nch, logic stb, logic ch, logic [3:0] f, logic eop);
        // f = {bad, backed_up, last, irq}
        logic hit;
        hit = stb && (f[0] || (f[1] && eop && !f[2]) || f[3]);
        if (hit && int'(ch) < nch) return 32'd1 << ch;
        return 32'd0;
    endfunction

    task automatic step(input logic ts, input logic tc, input logic [3:0] tf,
                        input logic rs, input logic rc, input logic [3:0] rf,
                        input logic eop, input logic we, input logic ws,
                        input logic [31:0] wd, input string tag);
        logic [31:0] tclr, rclr;
        tx_evt_stb = ts; tx_evt_chan = tc;
        {tx_evt_bad, tx_evt_backup, tx_evt_last, tx_evt_irq} = tf;
        rx_evt_stb = rs; rx_evt_chan = rc;
        {rx_evt_bad, rx_evt_backup, rx_evt_last, rx_evt_irq} = rf;
        eop_irq_en = eop; wr_en = we; wr_sel = ws; wr_data = wd;
        tclr = (we && !ws) ? (wd & 32'h3) : 32'd0;
        rclr = (we && ws) ? (wd & 32'h1) : 32'd0;
        m_tx = (m_tx & ~tclr) | set_of(2, ts, tc, tf, eop);
        m_rx = (m_rx & ~rclr) | set_of(1, rs, rc, rf, eop);
        @(posedge clk);
        #1;
        tx_evt_stb = 0; rx_evt_stb = 0; wr_en = 0;
        q.push_back('{cyc, 0, m_tx, tag});
        q.push_back('{cyc, 1, m_rx, tag});
        q.push_back('{cyc + 1, 2, {31'd0, |m_tx}, {tag, "/R8"}});
        q.push_back('{cyc + 1, 3, {31'd0, |m_rx}, {tag, "/R8"}});
        @(negedge clk);
    endtask

    task automatic direct(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        direct(tx_status, 32'd0, "R1 tx reset");
        direct(rx_status, 32'd0, "R1 rx reset");
        direct({30'd0, tx_irq, rx_irq}, 32'd0, "R1 irq reset");
        rst = 1'b0;
        @(negedge clk);

        step(1, 0, 4'b0001, 0, 0, 4'b0000, 0, 0, 0, 32'h0, "R2 irq flag ch0");
        step(1, 1, 4'b0000, 0, 0, 4'b0000, 1, 0, 0, 32'h0, "R2 no flag ch1");
        step(0, 0, 4'b0000, 0, 0, 4'b0000, 0, 1, 0, 32'h0, "R6 write zero");
        step(0, 0, 4'b0000, 0, 0, 4'b0000, 0, 1, 0, 32'h1, "R6 write one");
        step(1, 1, 4'b0010, 0, 0, 4'b0000, 1, 0, 0, 32'h0, "R3 eop enabled ch1");
        step(1, 0, 4'b0010, 0, 0, 4'b0000, 0, 0, 0, 32'h0, "R3 eop disabled ch0");
        step(1, 0, 4'b0110, 0, 0, 4'b0000, 1, 0, 0, 32'h0, "R4 backed up last");
        step(1, 0, 4'b0111, 0, 0, 4'b0000, 1, 0, 0, 32'h0, "R4 backed up with irq");
        step(0, 0, 4'b0000, 0, 0, 4'b0000, 0, 1, 0, 32'h3, "R6 clear both tx");
        step(0, 0, 4'b0000, 1, 0, 4'b1000, 0, 0, 0, 32'h0, "R5 rx bad packet");
        step(0, 0, 4'b0000, 1, 1, 4'b0001, 0, 0, 0, 32'h0, "R9 rx chan1 ignored");
        step(1, 1, 4'b1000, 0, 0, 4'b0000, 0, 0, 0, 32'h0, "R5 tx bad ch1");
        step(0, 0, 4'b0000, 0, 0, 4'b0000, 0, 1, 0, 32'hFFFF_FFFF, "R10 tx write all ones");
        step(0, 0, 4'b0000, 1, 0, 4'b1000, 0, 1, 1, 32'h1, "R7 rx set beats clear");
        step(1, 0, 4'b0001, 0, 0, 4'b0000, 0, 1, 0, 32'h1, "R7 tx set beats clear");
        step(1, 1, 4'b0001, 0, 0, 4'b0000, 0, 0, 0, 32'h0, "R2 irq flag ch1");

        rd_sel = 0; #1;
        direct(rd_data, 32'h3, "R9 read tx");
        rd_sel = 1; #1;
        direct(rd_data, 32'h1, "R9 read rx");

        step(0, 0, 4'b0000, 0, 0, 4'b0000, 0, 1, 1, 32'hFFFF_FFFF, "R10 rx write all ones");
        step(0, 0, 4'b0000, 0, 0, 4'b0000, 0, 0, 0, 32'h0, "R8 idle");
        rd_sel = 1; #1;
        direct(rd_data, 32'h0, "R9 read rx cleared");
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule